// File: doc/BRIEF.md
# Deferred Invalidate Queue with Acquire Barrier

This block sits between a coherence interconnect and the tag array of one cache. It takes each invalidate request from the interconnect, acknowledges it at once, and keeps the line address in an in-order queue. The tags are not touched on arrival. Queued addresses go to the tag array later over a separate valid/ready port, and each one that is delivered marks that line Invalid. While the tag port is willing, the queue empties in the background at one address per cycle.

A read barrier (acquire, or load-load ordering) is requested on a level input. While the barrier is in progress the block takes no new invalidates, so the barrier has a fixed set of addresses to apply. It drains every address still queued and then signals completion. Once completion has been seen, later loads cannot hit a stale copy of any line whose invalidate was acknowledged before the barrier. Loads themselves and the cache arrays lie outside the block.

Top module: `lazy_inval_queue`

## Requirements
- R1: While reset is asserted (rst_n low), tag_vld, inv_ack, bar_done and inv_full are all 0.
- R2: An invalidate is accepted on a clock edge where inv_vld is 1 and inv_full is 0. inv_ack is 1 for exactly the cycle after each acceptance, whatever the state of the tag port.
- R3: In a cycle where inv_vld is 0 or inv_full is 1, nothing is accepted. inv_ack is 0 in the following cycle, and that address never appears on tag_addr. inv_full is 1 whenever DEPTH addresses are queued.
- R4: tag_vld is 1 whenever the queue is not empty. tag_addr shows the oldest queued address. An address leaves the queue on an edge where tag_vld and tag_rdy are both 1, so addresses come out in acceptance order.
- R5: With no barrier in progress the queue drains at one address per cycle while tag_rdy is 1. While tag_rdy is 0, tag_vld stays 1 and tag_addr stays unchanged.
- R6: A barrier starts on the first edge where bar_req is 1 and no barrier is in progress. From that edge until the edge after bar_done, inv_full is 1 and no invalidate is accepted or acknowledged.
- R7: bar_done is a one-cycle pulse. It rises one cycle after the queue becomes empty during a barrier. If the queue is already empty when the barrier starts, bar_done is 1 in the second cycle after the edge that first samples bar_req high.
- R8: Every address accepted before a barrier starts is presented and taken on the tag port before bar_done rises. While bar_done is 1, tag_vld is 0.
- R9: Two queued invalidates to the same address are both kept and both delivered on the tag port, in order, with no merging.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_vld | input | 1 | Invalidate request from the interconnect is valid |
| inv_addr | input | ADDR_W | Line address to invalidate |
| inv_full | output | 1 | Back-pressure: requests are not taken while high |
| inv_ack | output | 1 | Acknowledge, one pulse per accepted request |
| tag_vld | output | 1 | A queued address is offered to the tag array |
| tag_addr | output | ADDR_W | Address whose line is to be marked Invalid |
| tag_rdy | input | 1 | Tag array takes the offered address this cycle |
| bar_req | input | 1 | Read barrier request, held until bar_done |
| bar_done | output | 1 | Barrier complete, single-cycle pulse |

## Verification
A queue pointer or fill count that goes wrong shows up on tag_addr as an address out of order, repeated or invented. It appears by the time that slot reaches the head, which is no more than DEPTH deliveries later. A count that drifts also moves inv_full at the wrong occupancy, so an acknowledged address is lost or an unacknowledged one is delivered; the scoreboard catches this the first time it pops. A barrier controller stuck in the wrong state shows within a cycle or two. Either bar_done rises while addresses are still offered, the pulse lands one cycle off from when the queue emptied, or inv_full fails to close intake while the drain runs.

// File: rtl/invq_pkg.sv
`timescale 1ns/1ps
package invq_pkg;

   // barrier sequencing: idle -> draining -> completion pulse -> idle
   typedef enum logic [1:0] {
      BAR_IDLE  = 2'd0,
      BAR_DRAIN = 2'd1,
      BAR_DONE  = 2'd2
   } bar_state_e;

   function automatic int unsigned fill_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/invq_fifo.sv
`timescale 1ns/1ps
module invq_fifo #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = invq_pkg::fill_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              pop,
   output logic [ADDR_W-1:0] head_addr,
   output logic              empty,
   output logic              full,
   output logic [CNT_W-1:0]  count
);

   localparam bit IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [ADDR_W-1:0] slots [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [PTR_W-1:0]  wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  fill;
   logic              do_push, do_pop;

   // pointer advance: free wrap for power-of-two depth, explicit wrap otherwise
   generate
      if (IS_POW2) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign full    = (fill == CNT_W'(DEPTH));
   assign empty   = (fill == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   // payload storage carries no reset; validity is tracked by fill
   always_ff @(posedge clk) begin
      if (do_push) slots[wr_ptr] <= push_addr;
   end

   assign head_addr = slots[rd_ptr];
   assign count     = fill;

endmodule

// File: rtl/invq_bar_ctl.sv
`timescale 1ns/1ps
module invq_bar_ctl
   import invq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bar_req,
   input  logic q_empty,
   output logic busy,
   output logic done
);

   bar_state_e st, st_nxt;

   always_comb begin
      st_nxt = st;
      unique case (st)
         BAR_IDLE:  if (bar_req) st_nxt = BAR_DRAIN;
         BAR_DRAIN: if (q_empty) st_nxt = BAR_DONE;
         BAR_DONE:  st_nxt = BAR_IDLE;
         default:   st_nxt = BAR_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= BAR_IDLE;
      else        st <= st_nxt;
   end

   assign busy = (st != BAR_IDLE);
   assign done = (st == BAR_DONE);

endmodule

// File: rtl/lazy_inval_queue.sv
`timescale 1ns/1ps
module lazy_inval_queue #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inv_vld,
   input  logic [ADDR_W-1:0] inv_addr,
   output logic              inv_full,
   output logic              inv_ack,
   output logic              tag_vld,
   output logic [ADDR_W-1:0] tag_addr,
   input  logic              tag_rdy,
   input  logic              bar_req,
   output logic              bar_done
);

   localparam int unsigned CNT_W = invq_pkg::fill_width(DEPTH);

   // elaboration-time parameter legality
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("lazy_inval_queue: DEPTH must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("lazy_inval_queue: ADDR_W must be at least 1");
      end
   endgenerate

   logic             q_empty, q_full;
   logic [CNT_W-1:0] q_count;
   logic             bar_busy;
   logic             accept;
   logic             pop;

   // intake is closed while full or while a barrier holds the set fixed
   assign inv_full = q_full | bar_busy;
   assign accept   = inv_vld & ~inv_full;
   assign tag_vld  = ~q_empty;
   assign pop      = tag_vld & tag_rdy;

   invq_fifo #(
      .ADDR_W (ADDR_W),
      .DEPTH  (DEPTH)
   ) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (accept),
      .push_addr (inv_addr),
      .pop       (pop),
      .head_addr (tag_addr),
      .empty     (q_empty),
      .full      (q_full),
      .count     (q_count)
   );

   invq_bar_ctl bar_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .bar_req (bar_req),
      .q_empty (q_empty),
      .busy    (bar_busy),
      .done    (bar_done)
   );

   // acknowledge goes out on enqueue, not on tag update
   always_ff @(posedge clk) begin
      if (!rst_n) inv_ack <= 1'b0;
      else        inv_ack <= accept;
   end

endmodule

// File: rtl/invq_checker.sv
`timescale 1ns/1ps
module invq_checker #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned CNT_W = invq_pkg::fill_width(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              inv_vld,
   input logic              inv_full,
   input logic              inv_ack,
   input logic              tag_vld,
   input logic              tag_rdy,
   input logic [ADDR_W-1:0] tag_addr,
   input logic              bar_done,
   input logic              bar_busy,
   input logic [CNT_W-1:0]  q_count
);

   p_ack_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_vld && !inv_full) |=> inv_ack);

   p_no_ack_unaccepted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(inv_vld && !inv_full) |=> !inv_ack);

   p_full_at_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count == CNT_W'(DEPTH)) |-> inv_full);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CNT_W'(DEPTH));

   p_offer_when_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count != '0) |-> tag_vld);

   p_hold_on_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_vld && !tag_rdy) |=> (tag_vld && $stable(tag_addr)));

   p_intake_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_busy && inv_vld) |=> !inv_ack);

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bar_done |=> !bar_done);

   p_done_after_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bar_done |-> $past(q_count == '0));

   p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bar_done |-> !tag_vld);

endmodule

bind lazy_inval_queue invq_checker #(
   .ADDR_W (ADDR_W),
   .DEPTH  (DEPTH)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .inv_vld  (inv_vld),
   .inv_full (inv_full),
   .inv_ack  (inv_ack),
   .tag_vld  (tag_vld),
   .tag_rdy  (tag_rdy),
   .tag_addr (tag_addr),
   .bar_done (bar_done),
   .bar_busy (bar_busy),
   .q_count  (q_count)
);

// File: tb/lazy_inval_queue_tb_top.sv
`timescale 1ns/1ps
module lazy_inval_queue_tb_top;

   localparam int AW = 16;
   localparam int DP = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          inv_vld;
   logic [AW-1:0] inv_addr;
   logic          inv_full;
   logic          inv_ack;
   logic          tag_vld;
   logic [AW-1:0] tag_addr;
   logic          tag_rdy;
   logic          bar_req;
   logic          bar_done;

   always #2.5 clk = ~clk;

   lazy_inval_queue #(.ADDR_W(AW), .DEPTH(DP)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .inv_vld  (inv_vld),
      .inv_addr (inv_addr),
      .inv_full (inv_full),
      .inv_ack  (inv_ack),
      .tag_vld  (tag_vld),
      .tag_addr (tag_addr),
      .tag_rdy  (tag_rdy),
      .bar_req  (bar_req),
      .bar_done (bar_done)
   );

   logic [AW-1:0] exp_q[$];
   int checks = 0;
   int bad = 0;
   int ncyc = 0;
   int last_pop_n = -10;
   int req_n = -10;
   bit prev_req = 1'b0;
   bit prev_acc = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // monitor: ack timing, barrier completion timing, tag-port scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         int m;
         ncyc++;
         chk(inv_ack == prev_acc, prev_acc ? "R2" : "R3", "ack after intake",
             int'(inv_ack), int'(prev_acc));
         prev_acc = inv_vld && !inv_full;
         if (bar_req && !prev_req) req_n = ncyc;
         prev_req = bar_req;
         if (bar_done) begin
            m = (last_pop_n > req_n) ? last_pop_n : req_n;
            chk(ncyc == m + 2, "R7", "done cycle", ncyc, m + 2);
            chk(!tag_vld, "R8", "tag_vld at done", int'(tag_vld), 0);
            chk(exp_q.size() == 0, "R8", "pending at done", exp_q.size(), 0);
         end
         if (tag_vld && tag_rdy) begin
            last_pop_n = ncyc;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4", "unexpected tag addr", int'(tag_addr), -1);
            end else begin
               logic [AW-1:0] e;
               e = exp_q.pop_front();
               chk(tag_addr == e, "R4", "tag addr order", int'(tag_addr), int'(e));
            end
         end
      end
   end

   // driver: holds a request until accepted, records it as expected output
   task automatic push_inv(input logic [AW-1:0] a);
      @(posedge clk); #1;
      inv_vld  = 1'b1;
      inv_addr = a;
      forever begin
         @(negedge clk);
         if (!inv_full) begin
            exp_q.push_back(a);
            break;
         end
      end
      @(posedge clk); #1;
      inv_vld = 1'b0;
   endtask

   // offer a request that must be refused for n cycles
   task automatic try_refused(input logic [AW-1:0] a, input int n, input string req);
      @(posedge clk); #1;
      inv_vld  = 1'b1;
      inv_addr = a;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(inv_full == 1'b1, req, "inv_full while refused", int'(inv_full), 1);
      end
      @(posedge clk); #1;
      inv_vld = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (bar_done) break;
      end
      chk(bar_done == 1'b1, "R7", "done seen", int'(bar_done), 1);
      #1 bar_req = 1'b0;
      @(negedge clk);
      chk(bar_done == 1'b0, "R7", "done single pulse", int'(bar_done), 0);
      chk(inv_full == 1'b0, "R6", "intake reopens", int'(inv_full), 0);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL R8 watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      logic [AW-1:0] held;
      rst_n    = 1'b0;
      inv_vld  = 1'b0;
      inv_addr = '0;
      tag_rdy  = 1'b0;
      bar_req  = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(tag_vld == 0,  "R1", "reset tag_vld",  int'(tag_vld), 0);
      chk(inv_ack == 0,  "R1", "reset inv_ack",  int'(inv_ack), 0);
      chk(bar_done == 0, "R1", "reset bar_done", int'(bar_done), 0);
      chk(inv_full == 0, "R1", "reset inv_full", int'(inv_full), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // background drain with a willing tag port (R4, R5)
      tag_rdy = 1'b1;
      for (int i = 0; i < 5; i++) push_inv(AW'(16'h0100 + i));
      idle(4);
      chk(exp_q.size() == 0, "R5", "background drained", exp_q.size(), 0);

      // fill to depth with a stalled tag port (R3, R5)
      tag_rdy = 1'b0;
      for (int i = 0; i < DP; i++) push_inv(AW'(16'h0A00 + i));
      @(negedge clk);
      chk(inv_full == 1'b1, "R3", "full at depth", int'(inv_full), 1);
      try_refused(16'hDEAD, 3, "R3");
      @(negedge clk);
      held = tag_addr;
      idle(3);
      @(negedge clk);
      chk(tag_vld == 1'b1, "R5", "offer held on stall", int'(tag_vld), 1);
      chk(tag_addr == held, "R5", "addr held on stall", int'(tag_addr), int'(held));
      chk(tag_addr == 16'h0A00, "R4", "oldest at head", int'(tag_addr), 16'h0A00);
      @(posedge clk); #1;
      tag_rdy = 1'b1;
      for (int i = 0; i < DP; i++) @(negedge clk);
      #1;
      chk(exp_q.size() == 0, "R5", "one per cycle drain", exp_q.size(), 0);
      idle(2);

      // barrier with pending work and a stalled tag port (R6, R7, R8)
      tag_rdy = 1'b0;
      push_inv(16'h0B01);
      push_inv(16'h0B02);
      push_inv(16'h0B03);
      @(posedge clk); #1;
      bar_req = 1'b1;
      try_refused(16'hBEEF, 3, "R6");
      chk(bar_done == 1'b0, "R8", "no done while pending", int'(bar_done), 0);
      @(posedge clk); #1;
      tag_rdy = 1'b1;
      wait_done();
      idle(3);

      // barrier on an empty queue (R7)
      @(posedge clk); #1;
      bar_req = 1'b1;
      wait_done();
      idle(2);

      // duplicate addresses are delivered twice (R9)
      push_inv(16'h0C55);
      push_inv(16'h0C55);
      push_inv(16'h0C66);
      idle(4);
      chk(exp_q.size() == 0, "R9", "duplicates delivered", exp_q.size(), 0);

      // duplicates queued before a barrier, drained by it (R9, R8)
      tag_rdy = 1'b0;
      push_inv(16'h0D10);
      push_inv(16'h0D10);
      @(posedge clk); #1;
      bar_req = 1'b1;
      idle(2);
      tag_rdy = 1'b1;
      wait_done();
      chk(exp_q.size() == 0, "R9", "duplicates drained by barrier", exp_q.size(), 0);

      idle(3);
      finish_run();
   end

endmodule